// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Loader

This block receives configuration words from a host controller over three lines: a serial clock, a serial data line and an enable line. It turns them into the latched settings of a frequency synthesizer and its companion blocks. All three lines are synchronised into the local clock domain. Every rising edge of the serial clock shifts one data bit into a shift register, most significant bit first. The enable line does not qualify individual bits. Its level picks one of two register spaces, and each change of level closes the frame that was being collected at the old level.

When the enable line is low, a frame is a 16-bit word. Its two leading bits route it to one of four targets: the control flags, the receive divide ratio, the reference divide ratio with its region selection, or the transmit divide ratio. When the enable line is high, a frame is a short trim word that sets the battery-threshold code and the oscillator capacitor selection. It arrives as either 12 or 16 bits. Its first bit acts as a write enable and is followed by don't-care padding. Every latched field comes out of reset at a fixed default. Downstream logic reads the settings straight from the output ports.

A two-state machine tracks which space is open. `S_WORD_SHIFT` collects word frames and moves to `S_TRIM_SHIFT` on a rising enable edge. `S_TRIM_SHIFT` collects trim frames and returns to `S_WORD_SHIFT` on a falling enable edge. Each transition is the only moment at which a frame can be committed.

Top module: `synth_loader`

## Requirements
- R1: After reset the receive ratio is 7215, the transmit ratio is 9966, the reference ratio is 2048, and the region select, all control flags, the battery threshold and the capacitor selection are zero.
- R2: A word frame is committed on the rising enable edge that ends it. Word bits 15:14 route it: 00 to control, 01 to the receive ratio, 10 to the reference register, 11 to the transmit ratio. Only the addressed register changes.
- R3: Control word fields, by word bit position: 12 transmit loop power save, 11 compressor mute, 10 compressor power-off, 9 expander mute, 8 expander power-off, 7 status pin select, 6 battery detector power save, 5 receive power save, 1 test mode bit 1, 0 test mode bit 0. Bits 13 and 4:2 are ignored.
- R4: A receive or transmit word loads its ratio from bits 13:0. A reference word loads the region select from bits 13:12 and the reference ratio from bits 11:0.
- R5: A divider word whose ratio field is below 16 leaves its register unchanged, region select included.
- R6: A word frame with fewer than 16 serial clocks leaves every word-space register unchanged.
- R7: A 12-bit trim frame is committed on the falling enable edge that ends it. It carries the write bit, one dummy bit, the battery threshold (4 bits, MSB first) and the capacitor selection (6 bits, MSB first).
- R8: A 16-bit trim frame carries the write bit, five dummy bits, then the same ten payload bits, and loads the same fields as R7.
- R9: A trim frame whose first bit is 0, or whose length is neither 12 nor 16 clocks, leaves the threshold and capacitor selection unchanged.
- R10: Output registers change only on the cycle that follows an enable edge. A fully shifted word has no effect until its frame is closed.
- R11: A word frame longer than 16 clocks uses the last 16 bits shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sclk | input | 1 | Host serial clock; bits taken on its rising edge |
| host_sdata | input | 1 | Host serial data, MSB first |
| host_sen | input | 1 | Host enable; level selects register space, each edge closes a frame |
| tx_loop_save | output | 1 | Transmit loop power save |
| comp_mute | output | 1 | Compressor mute |
| comp_off | output | 1 | Compressor power-off |
| exp_mute | output | 1 | Expander mute |
| exp_off | output | 1 | Expander power-off |
| status_sel | output | 1 | Status pin source select |
| batt_det_save | output | 1 | Battery detector power save |
| rx_save | output | 1 | Receive path power save |
| test_mode | output | 2 | Test mode code {bit1, bit0} |
| rx_ratio | output | 14 | Receive divide ratio |
| tx_ratio | output | 14 | Transmit divide ratio |
| ref_ratio | output | 12 | Reference divide ratio |
| region_sel | output | 2 | Reference region selection |
| batt_thresh | output | 4 | Battery threshold code |
| osc_trim | output | 6 | Oscillator capacitor selection |

## Verification
The bench targets the frame-closing corner cases: words of 15, 16 and 20 clocks; trim frames of 11, 12, 14 and 16 clocks; a trim frame with the write bit clear; and divider ratios of 15 and 16. A design that counted from the wrong end of the shift register would route a 20-bit word to the wrong target. One that loaded on every sixteenth bit would change a ratio before the enable edge. One that ignored the ratio floor would accept 15. A design that treated the dummy bits as payload would shift the threshold code by one place in one of the two trim lengths. A clock-by-clock model of the frame rules flags any of these on the exact cycle where it diverges.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;

    localparam int THR_W  = 4;
    localparam int TRIM_W = 6;

    typedef enum logic [0:0] {
        S_WORD_SHIFT = 1'b0,
        S_TRIM_SHIFT = 1'b1
    } ld_state_t;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'b00,
        SEL_RXDIV  = 2'b01,
        SEL_REFDIV = 2'b10,
        SEL_TXDIV  = 2'b11
    } reg_sel_t;

    typedef struct packed {
        logic tx_loop_save;
        logic comp_mute;
        logic comp_off;
        logic exp_mute;
        logic exp_off;
        logic status_sel;
        logic batt_det_save;
        logic rx_save;
        logic test_hi;
        logic test_lo;
    } ctl_flags_t;

endpackage

// File: rtl/synth_loader_sync.sv
module synth_loader_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] dly
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '0;
            end else begin
                pipe <= {pipe[STAGES-1:0], raw[g]};
            end
        end

        assign lvl[g] = pipe[STAGES-1];
        assign dly[g] = pipe[STAGES];
    end

endmodule

// File: rtl/synth_loader_shift.sv
module synth_loader_shift #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              bit_val,
    input  logic              clear,
    output logic [WORD_W-1:0] shreg,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              lead_bit
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            lead_bit <= 1'b0;
        end else if (clear) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            lead_bit <= 1'b0;
        end else if (bit_tick) begin
            shreg <= {shreg[WORD_W-2:0], bit_val};
            if (bit_cnt == '0) begin
                lead_bit <= bit_val;
            end
            if (bit_cnt != CNT_MAX) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/synth_loader_fsm.sv
module synth_loader_fsm
    import synth_loader_pkg::*;
#(
    parameter int CNT_W      = 5,
    parameter int WORD_W     = 16,
    parameter int TRIM_SHORT = 12,
    parameter int TRIM_LONG  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_rise,
    input  logic             en_fall,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             lead_bit,
    output ld_state_t        state,
    output logic             word_load,
    output logic             trim_load,
    output logic             frame_end
);

    localparam logic [CNT_W-1:0] WORD_LEN  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(TRIM_SHORT);
    localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(TRIM_LONG);

    ld_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_WORD_SHIFT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_WORD_SHIFT: if (en_rise) state_nx = S_TRIM_SHIFT;
            S_TRIM_SHIFT: if (en_fall) state_nx = S_WORD_SHIFT;
        endcase
    end

    always_comb begin
        word_load = 1'b0;
        trim_load = 1'b0;
        unique case (state)
            S_WORD_SHIFT: word_load = en_rise && (bit_cnt >= WORD_LEN);
            S_TRIM_SHIFT: trim_load = en_fall && lead_bit &&
                                      ((bit_cnt == SHORT_LEN) || (bit_cnt == LONG_LEN));
        endcase
    end

    assign frame_end = en_rise | en_fall;

endmodule

// File: rtl/synth_loader_regs.sv
module synth_loader_regs
    import synth_loader_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int DIV_MIN = 16,
    parameter int RX_DEF  = 7215,
    parameter int TX_DEF  = 9966,
    parameter int REF_DEF = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_load,
    input  logic              trim_load,
    input  logic [WORD_W-1:0] shreg,
    output ctl_flags_t        ctl,
    output logic [WORD_W-3:0] rx_ratio,
    output logic [WORD_W-3:0] tx_ratio,
    output logic [WORD_W-5:0] ref_ratio,
    output logic [1:0]        region_sel,
    output logic [THR_W-1:0]  batt_thresh,
    output logic [TRIM_W-1:0] osc_trim
);

    localparam int RATIO_W = WORD_W - 2;
    localparam int REF_W   = RATIO_W - 2;

    reg_sel_t           sel;
    logic [RATIO_W-1:0] ratio_f;
    logic [REF_W-1:0]   ref_f;
    logic               ratio_ok;
    logic               ref_ok;
    ctl_flags_t         ctl_f;

    assign sel      = reg_sel_t'(shreg[WORD_W-1 -: 2]);
    assign ratio_f  = shreg[RATIO_W-1:0];
    assign ref_f    = shreg[REF_W-1:0];
    assign ratio_ok = ratio_f >= RATIO_W'(DIV_MIN);
    assign ref_ok   = ref_f >= REF_W'(DIV_MIN);
    assign ctl_f    = '{tx_loop_save:  shreg[12], comp_mute: shreg[11],
                        comp_off:      shreg[10], exp_mute:  shreg[9],
                        exp_off:       shreg[8],  status_sel: shreg[7],
                        batt_det_save: shreg[6],  rx_save:   shreg[5],
                        test_hi:       shreg[1],  test_lo:   shreg[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl         <= '0;
            rx_ratio    <= RATIO_W'(RX_DEF);
            tx_ratio    <= RATIO_W'(TX_DEF);
            ref_ratio   <= REF_W'(REF_DEF);
            region_sel  <= '0;
            batt_thresh <= '0;
            osc_trim    <= '0;
        end else begin
            if (word_load) begin
                unique case (sel)
                    SEL_CTRL:   ctl <= ctl_f;
                    SEL_RXDIV:  if (ratio_ok) rx_ratio <= ratio_f;
                    SEL_TXDIV:  if (ratio_ok) tx_ratio <= ratio_f;
                    SEL_REFDIV: if (ref_ok) begin
                        ref_ratio  <= ref_f;
                        region_sel <= shreg[RATIO_W-1 -: 2];
                    end
                endcase
            end
            if (trim_load) begin
                batt_thresh <= shreg[THR_W+TRIM_W-1:TRIM_W];
                osc_trim    <= shreg[TRIM_W-1:0];
            end
        end
    end

endmodule

// File: rtl/synth_loader.sv
module synth_loader
    import synth_loader_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int TRIM_SHORT  = 12,
    parameter int TRIM_LONG   = 16,
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_MIN     = 16,
    parameter int RX_DEF      = 7215,
    parameter int TX_DEF      = 9966,
    parameter int REF_DEF     = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sclk,
    input  logic              host_sdata,
    input  logic              host_sen,
    output logic              tx_loop_save,
    output logic              comp_mute,
    output logic              comp_off,
    output logic              exp_mute,
    output logic              exp_off,
    output logic              status_sel,
    output logic              batt_det_save,
    output logic              rx_save,
    output logic [1:0]        test_mode,
    output logic [WORD_W-3:0] rx_ratio,
    output logic [WORD_W-3:0] tx_ratio,
    output logic [WORD_W-5:0] ref_ratio,
    output logic [1:0]        region_sel,
    output logic [THR_W-1:0]  batt_thresh,
    output logic [TRIM_W-1:0] osc_trim
);

    logic [2:0]        line_lvl;
    logic [2:0]        line_dly;
    logic              sclk_rise;
    logic              en_rise;
    logic              en_fall;
    logic              data_bit;
    logic              sync_unused;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              lead_bit;
    ld_state_t         state;
    logic              word_load;
    logic              trim_load;
    logic              frame_end;
    ctl_flags_t        ctl;

    synth_loader_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({host_sen, host_sdata, host_sclk}),
        .lvl   (line_lvl),
        .dly   (line_dly)
    );

    assign sclk_rise   = line_lvl[0] & ~line_dly[0];
    assign data_bit    = line_lvl[1];
    assign en_rise     = line_lvl[2] & ~line_dly[2];
    assign en_fall     = ~line_lvl[2] & line_dly[2];
    assign sync_unused = line_dly[1];

    synth_loader_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (sclk_rise),
        .bit_val  (data_bit),
        .clear    (frame_end),
        .shreg    (shreg),
        .bit_cnt  (bit_cnt),
        .lead_bit (lead_bit)
    );

    synth_loader_fsm #(
        .CNT_W(CNT_W), .WORD_W(WORD_W),
        .TRIM_SHORT(TRIM_SHORT), .TRIM_LONG(TRIM_LONG)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_rise   (en_rise),
        .en_fall   (en_fall),
        .bit_cnt   (bit_cnt),
        .lead_bit  (lead_bit),
        .state     (state),
        .word_load (word_load),
        .trim_load (trim_load),
        .frame_end (frame_end)
    );

    synth_loader_regs #(
        .WORD_W(WORD_W), .DIV_MIN(DIV_MIN),
        .RX_DEF(RX_DEF), .TX_DEF(TX_DEF), .REF_DEF(REF_DEF)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_load   (word_load),
        .trim_load   (trim_load),
        .shreg       (shreg),
        .ctl         (ctl),
        .rx_ratio    (rx_ratio),
        .tx_ratio    (tx_ratio),
        .ref_ratio   (ref_ratio),
        .region_sel  (region_sel),
        .batt_thresh (batt_thresh),
        .osc_trim    (osc_trim)
    );

    assign tx_loop_save  = ctl.tx_loop_save;
    assign comp_mute     = ctl.comp_mute;
    assign comp_off      = ctl.comp_off;
    assign exp_mute      = ctl.exp_mute;
    assign exp_off       = ctl.exp_off;
    assign status_sel    = ctl.status_sel;
    assign batt_det_save = ctl.batt_det_save;
    assign rx_save       = ctl.rx_save;
    assign test_mode     = {ctl.test_hi, ctl.test_lo};

endmodule

// File: rtl/synth_loader_chk.sv
module synth_loader_chk
    import synth_loader_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int CNT_W      = 5,
    parameter int DIV_MIN    = 16,
    parameter int TRIM_SHORT = 12,
    parameter int TRIM_LONG  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_rise,
    input logic              en_fall,
    input ld_state_t         state,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              lead_bit,
    input logic [WORD_W-1:0] shreg,
    input logic [9:0]        ctl_bits,
    input logic [WORD_W-3:0] rx_ratio,
    input logic [WORD_W-3:0] tx_ratio,
    input logic [WORD_W-5:0] ref_ratio,
    input logic [1:0]        region_sel,
    input logic [THR_W-1:0]  batt_thresh,
    input logic [TRIM_W-1:0] osc_trim
);

    localparam int RATIO_W = WORD_W - 2;
    localparam int REF_W   = RATIO_W - 2;
    localparam logic [CNT_W-1:0] WORD_LEN  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(TRIM_SHORT);
    localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(TRIM_LONG);

    // R10: no enable edge, no change on any output register
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_rise || en_fall) |=> $stable({ctl_bits, rx_ratio, tx_ratio, ref_ratio,
                                           region_sel, batt_thresh, osc_trim}));

    // R10: a rising enable edge always opens the trim space
    assert_space_R10: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> state == S_TRIM_SHIFT);

    // R5: ratios never fall below the floor
    assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ratio >= RATIO_W'(DIV_MIN) && tx_ratio >= RATIO_W'(DIV_MIN) &&
        ref_ratio >= REF_W'(DIV_MIN));

    // R6: a short word frame touches nothing in word space
    assert_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise && state == S_WORD_SHIFT && bit_cnt < WORD_LEN)
        |=> $stable({ctl_bits, rx_ratio, tx_ratio, ref_ratio, region_sel}));

    // R2: a complete receive word lands in the receive ratio only
    assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise && state == S_WORD_SHIFT && bit_cnt >= WORD_LEN &&
         shreg[WORD_W-1 -: 2] == 2'b01 && shreg[RATIO_W-1:0] >= RATIO_W'(DIV_MIN))
        |=> rx_ratio == $past(shreg[RATIO_W-1:0]) && $stable(tx_ratio) &&
            $stable(ref_ratio) && $stable(ctl_bits));

    // R9: an unqualified trim frame leaves the trim fields alone
    assert_trim_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall && state == S_TRIM_SHIFT &&
         !(lead_bit && (bit_cnt == SHORT_LEN || bit_cnt == LONG_LEN)))
        |=> $stable({batt_thresh, osc_trim}));

endmodule

bind synth_loader synth_loader_chk #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .DIV_MIN(DIV_MIN),
    .TRIM_SHORT(TRIM_SHORT), .TRIM_LONG(TRIM_LONG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_rise     (en_rise),
    .en_fall     (en_fall),
    .state       (state),
    .bit_cnt     (bit_cnt),
    .lead_bit    (lead_bit),
    .shreg       (shreg),
    .ctl_bits    (ctl),
    .rx_ratio    (rx_ratio),
    .tx_ratio    (tx_ratio),
    .ref_ratio   (ref_ratio),
    .region_sel  (region_sel),
    .batt_thresh (batt_thresh),
    .osc_trim    (osc_trim)
);

// File: tb/synth_loader_test.sv
module synth_loader_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic sen = 1'b0;

    logic tx_loop_save, comp_mute, comp_off, exp_mute, exp_off;
    logic status_sel, batt_det_save, rx_save;
    logic [1:0]  test_mode;
    logic [13:0] rx_ratio, tx_ratio;
    logic [11:0] ref_ratio;
    logic [1:0]  region_sel;
    logic [3:0]  batt_thresh;
    logic [5:0]  osc_trim;

    always #10 clk = ~clk;

    synth_loader uut (
        .clk(clk), .rst_n(rst_n),
        .host_sclk(sclk), .host_sdata(sdata), .host_sen(sen),
        .tx_loop_save(tx_loop_save), .comp_mute(comp_mute), .comp_off(comp_off),
        .exp_mute(exp_mute), .exp_off(exp_off), .status_sel(status_sel),
        .batt_det_save(batt_det_save), .rx_save(rx_save), .test_mode(test_mode),
        .rx_ratio(rx_ratio), .tx_ratio(tx_ratio), .ref_ratio(ref_ratio),
        .region_sel(region_sel), .batt_thresh(batt_thresh), .osc_trim(osc_trim)
    );

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // control word rebuilt at the R3 bit positions
    logic [15:0] dut_ctl;
    assign dut_ctl = {3'b000, tx_loop_save, comp_mute, comp_off, exp_mute, exp_off,
                      status_sel, batt_det_save, rx_save, 3'b000, test_mode};

    // reference model state
    int m_rx, m_tx, m_ref, m_reg, m_thr, m_cap, m_ctl;
    int m_cnt, m_lead;
    logic [31:0] m_sh;
    int p_sclk, p_en;
    logic [2:0] q[$];

    task automatic model_reset();
        m_rx = 7215; m_tx = 9966; m_ref = 2048; m_reg = 0;
        m_thr = 0; m_cap = 0; m_ctl = 0;
        m_cnt = 0; m_lead = 0; m_sh = '0;
        p_sclk = 0; p_en = 0;
        q.delete();
    endtask

    task automatic model_step(input logic [2:0] s);
        int w, r;
        if (int'(s[2]) != p_en) begin
            if (p_en == 0 && m_cnt >= 16) begin
                w = int'(m_sh[15:0]);
                case ((w >> 14) & 3)
                    0: m_ctl = w & 'h1FE3;
                    1: begin r = w & 'h3FFF; if (r >= 16) m_rx = r; end
                    2: begin r = w & 'hFFF; if (r >= 16) begin m_ref = r; m_reg = (w >> 12) & 3; end end
                    default: begin r = w & 'h3FFF; if (r >= 16) m_tx = r; end
                endcase
            end else if (p_en == 1 && m_lead == 1 && (m_cnt == 12 || m_cnt == 16)) begin
                m_thr = int'(m_sh[9:6]);
                m_cap = int'(m_sh[5:0]);
            end
            m_cnt = 0; m_sh = '0; m_lead = 0;
        end else if (s[0] && p_sclk == 0) begin
            if (m_cnt == 0) m_lead = int'(s[1]);
            m_sh = {m_sh[30:0], s[1]};
            if (m_cnt < 31) m_cnt++;
        end
        p_sclk = int'(s[0]);
        p_en = int'(s[2]);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            q.push_back({sen, sdata, sclk});
            if (q.size() >= 3) model_step(q.pop_front());
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check_eq(cur_req, "rx_ratio", int'(rx_ratio), m_rx);
            check_eq(cur_req, "tx_ratio", int'(tx_ratio), m_tx);
            check_eq(cur_req, "ref_ratio", int'(ref_ratio), m_ref);
            check_eq(cur_req, "region_sel", int'(region_sel), m_reg);
            check_eq(cur_req, "ctl", int'(dut_ctl), m_ctl);
            check_eq(cur_req, "batt_thresh", int'(batt_thresh), m_thr);
            check_eq(cur_req, "osc_trim", int'(osc_trim), m_cap);
        end
    end

    task automatic put_bit(input logic b);
        @(negedge clk) sdata = b;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) put_bit(bits[i]);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_en(input logic v);
        @(negedge clk) sen = v;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] bits, input int n);
        shift_bits(bits, n);
        set_en(1'b1);
        set_en(1'b0);
    endtask

    task automatic send_trim(input logic [31:0] bits, input int n);
        set_en(1'b1);
        shift_bits(bits, n);
        set_en(1'b0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        cur_req = "R1";
        check_eq("R1", "rx default", int'(rx_ratio), 7215);
        check_eq("R1", "tx default", int'(tx_ratio), 9966);
        check_eq("R1", "ref default", int'(ref_ratio), 2048);
        check_eq("R1", "region default", int'(region_sel), 0);
        check_eq("R1", "ctl default", int'(dut_ctl), 0);
        check_eq("R1", "thresh default", int'(batt_thresh), 0);
        check_eq("R1", "trim default", int'(osc_trim), 0);

        cur_req = "R4";
        send_word(32'h4000 | 1000, 16);
        check_eq("R4", "rx load", int'(rx_ratio), 1000);
        check_eq("R2", "tx untouched by rx word", int'(tx_ratio), 9966);
        send_word(32'hC000 | 16383, 16);
        check_eq("R4", "tx max", int'(tx_ratio), 16383);
        check_eq("R2", "rx untouched by tx word", int'(rx_ratio), 1000);
        send_word(32'h8000 | (2 << 12) | 100, 16);
        check_eq("R4", "ref load", int'(ref_ratio), 100);
        check_eq("R4", "region load", int'(region_sel), 2);

        cur_req = "R3";
        send_word(32'h36BE, 16);
        check_eq("R3", "ctl fields", int'(dut_ctl), 'h16A2);
        check_eq("R3", "comp_off", int'(comp_off), 1);
        check_eq("R3", "comp_mute", int'(comp_mute), 0);
        check_eq("R3", "test_mode", int'(test_mode), 2);
        check_eq("R2", "rx untouched by ctl word", int'(rx_ratio), 1000);

        cur_req = "R5";
        send_word(32'h4000 | 15, 16);
        check_eq("R5", "ratio 15 rejected", int'(rx_ratio), 1000);
        send_word(32'h4000 | 16, 16);
        check_eq("R5", "ratio 16 accepted", int'(rx_ratio), 16);
        send_word(32'h8000 | (3 << 12) | 5, 16);
        check_eq("R5", "ref floor ratio", int'(ref_ratio), 100);
        check_eq("R5", "ref floor region", int'(region_sel), 2);

        cur_req = "R6";
        send_word(32'h4000 | 500, 15);
        check_eq("R6", "15-clock word", int'(rx_ratio), 16);

        cur_req = "R11";
        send_word({12'h0, 4'hF, 16'hC000 | 16'd4242}, 20);
        check_eq("R11", "20-clock word", int'(tx_ratio), 4242);
        check_eq("R11", "rx kept", int'(rx_ratio), 16);

        cur_req = "R10";
        shift_bits(32'h4000 | 777, 16);
        check_eq("R10", "before enable edge", int'(rx_ratio), 16);
        set_en(1'b1);
        check_eq("R10", "after enable edge", int'(rx_ratio), 777);
        set_en(1'b0);

        cur_req = "R7";
        send_trim(32'b1_0_1111_011100, 12);
        check_eq("R7", "12-bit thresh", int'(batt_thresh), 15);
        check_eq("R7", "12-bit trim", int'(osc_trim), 28);
        check_eq("R7", "rx kept", int'(rx_ratio), 777);

        cur_req = "R8";
        send_trim(32'b1_10101_0101_100011, 16);
        check_eq("R8", "16-bit thresh", int'(batt_thresh), 5);
        check_eq("R8", "16-bit trim", int'(osc_trim), 35);

        cur_req = "R9";
        send_trim(32'b0_0_0011_000001, 12);
        check_eq("R9", "write bit clear", int'(batt_thresh), 5);
        send_trim(32'b1_000_0011_000001, 14);
        check_eq("R9", "14-clock trim", int'(osc_trim), 35);
        send_trim(32'b1_0011_000001, 11);
        check_eq("R9", "11-clock trim", int'(batt_thresh), 5);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule